// File: doc/BRIEF.md
# Serial Command to Register Bus Bridge

This block lets a host drive a parallel register bus over a two-wire serial link. Bytes arriving on the receive line are grouped into packets of four parts: a command byte, a subcommand byte, a length byte, and a payload whose size is given by the length byte. Write packets become one bus write strobe per data byte. Read packets become a run of bus read strobes. Each byte read back is queued and sent out on the transmit line. An echo packet is answered by the bridge alone and is a quick way to confirm that the link is alive. A reset packet clears the bridge's own decoder and transmit queue and leaves the register side untouched.

Each bus transfer carries a 32-bit address and an 8-bit byte index. The address stays fixed for the whole packet, and the index counts up from zero, one step per byte. Both the receiver and the transmitter use 8N1 framing. The bit period is a parameter in clock cycles; its default of 32 gives 230400 bps from a 7.37 MHz clock. The host sends one packet and then waits for any reply before it sends the next.

Top module: `sercmd_bridge`

## Requirements
- R1: Out of reset the transmit line is high, and both bus strobes and the transmitter's busy flag are low. Whenever the transmitter is idle, the line is high.
- R2: Transmitted bytes use 8N1 framing: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts BIT_CYC clock cycles.
- R3: A write packet is command 0x23, subcommand 0x57, length 4+n with n of at least 1, then four address bytes (least significant first), then n data bytes. It produces n one-cycle bus_wr_o pulses carrying the same address, the data bytes in order, and bus_idx_o values 0 to n-1.
- R4: A read packet is 0x23, 0x52, length 5, four address bytes (least significant first), then a count c. It produces c one-cycle bus_rd_o pulses with bus_idx_o values 0 to c-1 and a fixed address. The bridge samples bus_rdata_i in the cycle after each pulse, and the bytes are transmitted in ascending index order.
- R5: A read packet with a count of 0 produces no bus strobe and no transmitted byte.
- R6: An echo packet is 0x23, 0x45, length 4, then four bytes. The four bytes are transmitted back in order, and no bus strobe is produced.
- R7: Any packet whose command, subcommand or length does not match one of the valid forms is discarded. This includes a write of length 4 or less, a read whose length is not 5, and a length of 0. Exactly `length` payload bytes are skipped, with no bus strobe and no transmitted byte, and the packet that follows is decoded normally.
- R8: The packet 0x24, 0x72, length 1, then one byte (whose value is ignored) returns the decoder to idle and drops every queued transmit byte that has not yet started. A byte already being sent is completed. It produces no bus strobe, and the bridge accepts packets afterwards.
- R9: bus_wr_o and bus_rd_o are never high in the same cycle. The transmit queue never takes a byte while full. When a read asks for more bytes than the queue holds, the strobes pause until there is room, and no byte is lost.
- R10: The receiver samples each bit at its middle. A low pulse on the receive line shorter than half a bit period is not taken as a start bit and yields no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tx_o | output | 1 | Serial transmit line, idle high |
| bus_addr_o | output | ADDR_W | Register address for the current packet |
| bus_idx_o | output | IDX_W | Byte index within the transfer |
| bus_wdata_o | output | 8 | Write data byte |
| bus_wr_o | output | 1 | One-cycle write strobe |
| bus_rd_o | output | 1 | One-cycle read strobe |
| bus_rdata_i | input | 8 | Read data, valid in the cycle after bus_rd_o |

## Verification
Bad decoder state shows up in two ways: as bus strobes that are missing, extra or carry the wrong index, and as transmit bytes that are missing, reordered or unexpected. These faults appear within a byte period or two of the packet's last byte. A transmit queue pointer fault appears as a wrong byte on the serial line during the same response. The bench drives an oversized read to reach the full-queue stall, and a reset packet while replies are still queued to reach the flush. A short receive-line glitch checks that the start bit is qualified before any bits are sampled.

// File: rtl/sb_pkg.sv
package sb_pkg;
   localparam logic [7:0] CMD_REG  = 8'h23;
   localparam logic [7:0] CMD_SYS  = 8'h24;
   localparam logic [7:0] SUB_WR   = 8'h57;
   localparam logic [7:0] SUB_RD   = 8'h52;
   localparam logic [7:0] SUB_ECHO = 8'h45;
   localparam logic [7:0] SUB_RST  = 8'h72;
   localparam logic [7:0] LEN_ECHO = 8'd4;
   localparam logic [7:0] LEN_RST  = 8'd1;

   typedef enum logic [3:0] {
      S_CMD, S_SCMD, S_LEN, S_ADDR, S_WDATA, S_RCNT,
      S_RISSUE, S_RWAIT, S_RSAMP, S_ECHO, S_SKIP, S_RSTB
   } dec_state_t;

   typedef enum logic [2:0] {OP_BAD, OP_WR, OP_RD, OP_ECHO, OP_RST} op_t;

   // Decide the packet kind once the length byte is known.
   function automatic op_t classify(input logic [7:0] c, input logic [7:0] s,
                                    input logic [7:0] l, input logic [7:0] ab);
      op_t k;
      k = OP_BAD;
      if (c == CMD_REG && s == SUB_WR && l > ab)                 k = OP_WR;
      else if (c == CMD_REG && s == SUB_RD && l == 8'(ab + 8'd1)) k = OP_RD;
      else if (c == CMD_REG && s == SUB_ECHO && l == LEN_ECHO)    k = OP_ECHO;
      else if (c == CMD_SYS && s == SUB_RST && l == LEN_RST)      k = OP_RST;
      return k;
   endfunction
endpackage

// File: rtl/sb_uart_rx.sv
module sb_uart_rx #(
   parameter int BIT_CYC     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_i,
   output logic       vld_o,
   output logic [7:0] data_o
);
   localparam int CW   = $clog2(BIT_CYC);
   localparam int HALF = BIT_CYC / 2;

   logic rx_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rx_i;
      end else if (SYNC_STAGES == 1) begin : g_sync1
         logic r1;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r1 <= 1'b1;
            else        r1 <= rx_i;
         assign rx_s = r1;
      end else begin : g_syncn
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sr <= '1;
            else        sr <= {sr[SYNC_STAGES-2:0], rx_i};
         assign rx_s = sr[SYNC_STAGES-1];
      end
   endgenerate

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_t;
   rx_st_t        st;
   logic [CW-1:0] cnt;
   logic [2:0]    nbit;
   logic [7:0]    sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= RX_IDLE;
         cnt    <= '0;
         nbit   <= '0;
         sh     <= '0;
         vld_o  <= 1'b0;
         data_o <= '0;
      end else begin
         vld_o <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               cnt <= '0;
               if (!rx_s) st <= RX_START;
            end
            RX_START: begin
               if (cnt == CW'(HALF - 1)) begin
                  cnt  <= '0;
                  nbit <= '0;
                  st   <= rx_s ? RX_IDLE : RX_DATA;
               end else cnt <= cnt + 1'b1;
            end
            RX_DATA: begin
               if (cnt == CW'(BIT_CYC - 1)) begin
                  cnt  <= '0;
                  sh   <= {rx_s, sh[7:1]};
                  nbit <= nbit + 1'b1;
                  if (nbit == 3'd7) st <= RX_STOP;
               end else cnt <= cnt + 1'b1;
            end
            RX_STOP: begin
               if (cnt == CW'(BIT_CYC - 1)) begin
                  cnt <= '0;
                  st  <= RX_IDLE;
                  if (rx_s) begin
                     vld_o  <= 1'b1;
                     data_o <= sh;
                  end
               end else cnt <= cnt + 1'b1;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sb_uart_tx.sv
module sb_uart_tx #(
   parameter int BIT_CYC = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go_i,
   input  logic [7:0] data_i,
   output logic       tx_o,
   output logic       busy_o
);
   localparam int CW = $clog2(BIT_CYC);

   logic [9:0]    sh;
   logic [CW-1:0] cnt;
   logic [3:0]    nleft;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '1;
         cnt    <= '0;
         nleft  <= '0;
         tx_o   <= 1'b1;
         busy_o <= 1'b0;
      end else if (!busy_o) begin
         if (go_i) begin
            sh     <= {1'b1, data_i, 1'b0};
            tx_o   <= 1'b0;
            busy_o <= 1'b1;
            cnt    <= '0;
            nleft  <= 4'd9;
         end
      end else if (cnt == CW'(BIT_CYC - 1)) begin
         cnt <= '0;
         if (nleft == 4'd0) busy_o <= 1'b0;
         else begin
            tx_o  <= sh[1];
            sh    <= {1'b1, sh[9:1]};
            nleft <= nleft - 1'b1;
         end
      end else cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sb_byteq.sv
module sb_byteq #(
   parameter int DEPTH = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       flush_i,
   input  logic       push_i,
   input  logic [7:0] pdata_i,
   input  logic       pop_i,
   output logic [7:0] head_o,
   output logic       empty_o,
   output logic       full_o
);
   localparam int AW = $clog2(DEPTH);

   logic [7:0]  mem [DEPTH];
   logic [AW:0] wp, rp;

   assign empty_o = (wp == rp);
   assign full_o  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign head_o  = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush_i) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push_i && !full_o) wp <= wp + 1'b1;
         if (pop_i && !empty_o) rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk)
      if (push_i && !full_o) mem[wp[AW-1:0]] <= pdata_i;
endmodule

// File: rtl/sb_decoder.sv
module sb_decoder
   import sb_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_vld_i,
   input  logic [7:0]        rx_data_i,
   input  logic              q_full_i,
   output logic              q_push_o,
   output logic [7:0]        q_data_o,
   output logic              srst_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [IDX_W-1:0]  bus_idx_o,
   output logic [7:0]        bus_wdata_o,
   output logic              bus_wr_o,
   output logic              bus_rd_o,
   input  logic [7:0]        bus_rdata_i
);
   localparam int         AB   = ADDR_W / 8;
   localparam int         ABW  = (AB > 1) ? $clog2(AB) : 1;
   localparam logic [7:0] AB8  = 8'(AB);

   dec_state_t     st;
   op_t            op, op_c;
   logic [7:0]     cmd, scmd, rem, rcnt;
   logic [ABW-1:0] abyte;

   assign op_c = classify(cmd, scmd, rx_data_i, AB8);

   always_comb begin
      q_push_o = 1'b0;
      q_data_o = rx_data_i;
      if (st == S_RSAMP) begin
         q_push_o = 1'b1;
         q_data_o = bus_rdata_i;
      end else if (st == S_ECHO && rx_vld_i && !q_full_i) begin
         q_push_o = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_CMD;
         op          <= OP_BAD;
         cmd         <= '0;
         scmd        <= '0;
         rem         <= '0;
         rcnt        <= '0;
         abyte       <= '0;
         srst_o      <= 1'b0;
         bus_addr_o  <= '0;
         bus_idx_o   <= '0;
         bus_wdata_o <= '0;
         bus_wr_o    <= 1'b0;
         bus_rd_o    <= 1'b0;
      end else begin
         bus_wr_o <= 1'b0;
         bus_rd_o <= 1'b0;
         srst_o   <= 1'b0;
         if (bus_wr_o) bus_idx_o <= bus_idx_o + 1'b1;
         unique case (st)
            S_CMD:  if (rx_vld_i) begin cmd  <= rx_data_i; st <= S_SCMD; end
            S_SCMD: if (rx_vld_i) begin scmd <= rx_data_i; st <= S_LEN;  end
            S_LEN: if (rx_vld_i) begin
               op    <= op_c;
               rem   <= rx_data_i;
               abyte <= '0;
               unique case (op_c)
                  OP_WR, OP_RD: st <= S_ADDR;
                  OP_ECHO:      st <= S_ECHO;
                  OP_RST:       st <= S_RSTB;
                  default:      st <= (rx_data_i == 8'd0) ? S_CMD : S_SKIP;
               endcase
            end
            S_ADDR: if (rx_vld_i) begin
               bus_addr_o[abyte*8 +: 8] <= rx_data_i;
               abyte <= abyte + 1'b1;
               rem   <= rem - 1'b1;
               if (abyte == ABW'(AB - 1)) begin
                  bus_idx_o <= '0;
                  st <= (op == OP_WR) ? S_WDATA : S_RCNT;
               end
            end
            S_WDATA: if (rx_vld_i) begin
               bus_wr_o    <= 1'b1;
               bus_wdata_o <= rx_data_i;
               rem         <= rem - 1'b1;
               if (rem == 8'd1) st <= S_CMD;
            end
            S_RCNT: if (rx_vld_i) begin
               rcnt <= rx_data_i;
               st   <= (rx_data_i == 8'd0) ? S_CMD : S_RISSUE;
            end
            S_RISSUE: if (!q_full_i) begin
               bus_rd_o <= 1'b1;
               st       <= S_RWAIT;
            end
            S_RWAIT: st <= S_RSAMP;
            S_RSAMP: begin
               bus_idx_o <= bus_idx_o + 1'b1;
               rcnt      <= rcnt - 1'b1;
               st        <= (rcnt == 8'd1) ? S_CMD : S_RISSUE;
            end
            S_ECHO, S_SKIP: if (rx_vld_i) begin
               rem <= rem - 1'b1;
               if (rem == 8'd1) st <= S_CMD;
            end
            S_RSTB: if (rx_vld_i) begin
               srst_o <= 1'b1;
               st     <= S_CMD;
            end
            default: st <= S_CMD;
         endcase
         if (srst_o) begin
            st         <= S_CMD;
            bus_idx_o  <= '0;
            bus_addr_o <= '0;
         end
      end
   end
endmodule

// File: rtl/sercmd_bridge.sv
module sercmd_bridge #(
   parameter int BIT_CYC     = 32,
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 8,
   parameter int Q_DEPTH     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   output logic              tx_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [IDX_W-1:0]  bus_idx_o,
   output logic [7:0]        bus_wdata_o,
   output logic              bus_wr_o,
   output logic              bus_rd_o,
   input  logic [7:0]        bus_rdata_i
);
   generate
      if (BIT_CYC < 4) begin : g_bad_bit
         $error("BIT_CYC must be at least 4");
      end
      if (ADDR_W % 8 != 0 || ADDR_W < 8 || ADDR_W > 64) begin : g_bad_addr
         $error("ADDR_W must be a whole number of bytes, 8 to 64");
      end
      if (IDX_W < 8) begin : g_bad_idx
         $error("IDX_W must hold an 8-bit count");
      end
      if (Q_DEPTH < 4 || (Q_DEPTH & (Q_DEPTH - 1)) != 0) begin : g_bad_q
         $error("Q_DEPTH must be a power of two, at least 4");
      end
   endgenerate

   logic       rx_vld, q_push, q_full, q_empty, tx_busy, tx_go, srst;
   logic [7:0] rx_data, q_data, q_head;

   assign tx_go = !tx_busy && !q_empty;

   sb_uart_rx #(.BIT_CYC(BIT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .vld_o(rx_vld), .data_o(rx_data)
   );

   sb_decoder #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .rx_vld_i(rx_vld), .rx_data_i(rx_data),
      .q_full_i(q_full), .q_push_o(q_push), .q_data_o(q_data), .srst_o(srst),
      .bus_addr_o(bus_addr_o), .bus_idx_o(bus_idx_o), .bus_wdata_o(bus_wdata_o),
      .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i)
   );

   sb_byteq #(.DEPTH(Q_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .flush_i(srst), .push_i(q_push), .pdata_i(q_data),
      .pop_i(tx_go), .head_o(q_head), .empty_o(q_empty), .full_o(q_full)
   );

   sb_uart_tx #(.BIT_CYC(BIT_CYC)) u_tx (
      .clk(clk), .rst_n(rst_n), .go_i(tx_go), .data_i(q_head),
      .tx_o(tx_o), .busy_o(tx_busy)
   );
endmodule

// File: rtl/sb_check.sv
module sb_check #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [IDX_W-1:0]  bus_idx,
   input logic              tx,
   input logic              tx_busy,
   input logic              q_push,
   input logic              q_full
);
   assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_rd));

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> !q_full);

   assert_rd_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> !bus_rd);

   assert_rd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> ($stable(bus_addr) && $stable(bus_idx)));

   assert_wr_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> !bus_wr);

   assert_tx_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> tx);
endmodule

bind sercmd_bridge sb_check #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr_o), .bus_rd(bus_rd_o),
   .bus_addr(bus_addr_o), .bus_idx(bus_idx_o), .tx(tx_o), .tx_busy(tx_busy),
   .q_push(q_push), .q_full(q_full)
);

// File: tb/sim_sercmd_bridge.sv
module sim_sercmd_bridge;
   localparam int BIT = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx = 1'b1;
   logic        tx;
   logic [31:0] addr;
   logic [7:0]  idx, wdata, rdata = 8'h00;
   logic        wr, rd;

   always #10 clk = ~clk;

   sercmd_bridge u0 (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx),
      .bus_addr_o(addr), .bus_idx_o(idx), .bus_wdata_o(wdata),
      .bus_wr_o(wr), .bus_rd_o(rd), .bus_rdata_i(rdata)
   );

   int    nvec = 0, nbad = 0;
   bit    done = 0;
   string tag = "R1";

   logic [7:0]  expt[$];
   logic [47:0] expw[$];
   logic [39:0] expr[$];
   logic [7:0]  pkt[$];

   function automatic logic [7:0] rmodel(logic [31:0] a, logic [7:0] i);
      return (a[7:0] ^ a[31:24]) + i * 8'd7 + 8'h3C;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [47:0] act, logic [47:0] exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Bus side: register model and strobe scoreboard.
   always @(negedge clk) begin
      if (rst_n && wr) begin
         if (expw.size() == 0) chk(0, tag, "unexpected write", {addr, idx, wdata}, 48'h0);
         else begin
            logic [47:0] e;
            e = expw.pop_front();
            chk({addr, idx, wdata} == e, tag, "write strobe", {addr, idx, wdata}, e);
         end
      end
      if (rst_n && rd) begin
         rdata <= rmodel(addr, idx);
         if (expr.size() == 0) chk(0, tag, "unexpected read", {8'h0, addr, idx}, 48'h0);
         else begin
            logic [39:0] e;
            e = expr.pop_front();
            chk({addr, idx} == e, tag, "read strobe", {8'h0, addr, idx}, {8'h0, e});
         end
      end
   end

   // Serial monitor: decode 8N1 frames and compare with the expected queue (R2).
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && tx == 1'b0) begin
            logic [7:0] b;
            logic       ok_frame;
            repeat (BIT / 2 - 1) @(negedge clk);
            ok_frame = (tx == 1'b0);
            for (int i = 0; i < 8; i++) begin
               repeat (BIT) @(negedge clk);
               b[i] = tx;
            end
            repeat (BIT) @(negedge clk);
            ok_frame = ok_frame && (tx == 1'b1);
            chk(ok_frame, "R2", "frame start/stop", {47'h0, ok_frame}, 48'h1);
            if (expt.size() == 0) chk(0, tag, "unexpected tx byte", {40'h0, b}, 48'h0);
            else begin
               logic [7:0] e;
               e = expt.pop_front();
               chk(b == e, tag, "tx byte", {40'h0, b}, {40'h0, e});
            end
         end
      end
   end

   task automatic send_byte(logic [7:0] b);
      rx = 1'b0;
      repeat (BIT) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx = b[i];
         repeat (BIT) @(negedge clk);
      end
      rx = 1'b1;
      repeat (BIT) @(negedge clk);
   endtask

   task automatic send_pkt();
      while (pkt.size() > 0) send_byte(pkt.pop_front());
   endtask

   task automatic put_addr(logic [31:0] a);
      for (int i = 0; i < 4; i++) pkt.push_back(a[8*i +: 8]);
   endtask

   task automatic settle(int bytes);
      repeat (BIT * 10 * bytes + 300) @(negedge clk);
      chk(expw.size() == 0, tag, "writes left", 48'(expw.size()), 48'h0);
      chk(expr.size() == 0, tag, "reads left", 48'(expr.size()), 48'h0);
      chk(expt.size() == 0, tag, "tx bytes left", 48'(expt.size()), 48'h0);
   endtask

   task automatic do_write(logic [31:0] a, int n, logic [7:0] seed);
      pkt.push_back(8'h23); pkt.push_back(8'h57); pkt.push_back(8'(4 + n));
      put_addr(a);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = seed + 8'(i * 29);
         pkt.push_back(d);
         expw.push_back({a, 8'(i), d});
      end
      send_pkt();
   endtask

   task automatic do_read(logic [31:0] a, int n);
      pkt.push_back(8'h23); pkt.push_back(8'h52); pkt.push_back(8'd5);
      put_addr(a);
      pkt.push_back(8'(n));
      for (int i = 0; i < n; i++) begin
         expr.push_back({a, 8'(i)});
         expt.push_back(rmodel(a, 8'(i)));
      end
      send_pkt();
   endtask

   task automatic do_echo(logic [31:0] p);
      pkt.push_back(8'h23); pkt.push_back(8'h45); pkt.push_back(8'd4);
      for (int i = 0; i < 4; i++) begin
         pkt.push_back(p[8*i +: 8]);
         expt.push_back(p[8*i +: 8]);
      end
      send_pkt();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nvec++;
         nbad++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      tag = "R1";
      chk(tx == 1'b1, "R1", "tx idle", {47'h0, tx}, 48'h1);
      chk(wr == 1'b0, "R1", "wr idle", {47'h0, wr}, 48'h0);
      chk(rd == 1'b0, "R1", "rd idle", {47'h0, rd}, 48'h0);

      // R3: multi-byte and single-byte writes
      tag = "R3";
      do_write(32'h1234_5678, 3, 8'hAA);
      settle(1);
      do_write(32'hDEAD_BEEF, 1, 8'h5C);
      settle(1);

      // R6: echo answered without bus activity
      tag = "R6";
      do_echo(32'h0403_0201);
      settle(5);

      // R4: read of three bytes
      tag = "R4";
      do_read(32'h0000_0040, 3);
      settle(4);

      // R5: zero-count read
      tag = "R5";
      do_read(32'h8000_0001, 0);
      settle(1);

      // R7: invalid packets are skipped, following packet still works
      tag = "R7";
      pkt = '{8'h23, 8'h99, 8'h03, 8'h11, 8'h22, 8'h33};
      send_pkt();
      pkt = '{8'h30, 8'h57, 8'h05, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05};
      send_pkt();
      pkt = '{8'h23, 8'h52, 8'h04, 8'h10, 8'h20, 8'h30, 8'h40};
      send_pkt();
      pkt = '{8'h23, 8'h57, 8'h04, 8'h23, 8'h57, 8'h05, 8'h00};
      send_pkt();
      pkt = '{8'h23, 8'h11, 8'h00};
      send_pkt();
      do_echo(32'hCAFE_F00D);
      settle(5);

      // R10: short low glitch is not a start bit
      tag = "R10";
      rx = 1'b0;
      repeat (6) @(negedge clk);
      rx = 1'b1;
      repeat (BIT * 12) @(negedge clk);
      do_echo(32'h7766_5544);
      settle(5);

      // R9: read larger than the queue stalls without loss
      tag = "R9";
      do_read(32'h0102_0304, 20);
      settle(21);

      // R8: reset packet flushes queued replies, then bridge works again
      tag = "R8";
      do_read(32'h00AB_CD00, 12);
      pkt = '{8'h24, 8'h72, 8'h01, 8'h5A};
      send_pkt();
      repeat (BIT * 10 * 10) @(negedge clk);
      chk(expr.size() == 0, "R8", "reads issued before reset", 48'(expr.size()), 48'h0);
      chk(expt.size() > 0 && expt.size() < 12, "R8", "queued bytes dropped",
          48'(expt.size()), 48'h1);
      expt.delete();
      do_echo(32'h0BAD_F1E1);
      settle(5);
      do_write(32'h0000_0100, 2, 8'h01);
      settle(1);

      done = 1;
      summary();
      $finish;
   end
endmodule